// File: doc/BRIEF.md
# Hybrid Counter/Ring Pulse-Width Modulator

This block produces a fixed-frequency pulse train whose high time is set by an 8-bit duty word. The switching period is divided into 256 slots. A one-hot token circulates around a 32-stage ring, advancing one stage per fast clock, and each completed revolution steps a 3-bit coarse counter. The slot index is therefore the counter value concatenated with the token position. The output is set when the slot index returns to zero and cleared when the counter equals the upper three duty bits while the token sits at the stage named by the lower five duty bits.

The duty word is clamped to 8..249 and captured only when a period begins, so changing it mid-period cannot disturb the pulse in flight. An enable input, also captured at period start, decides whether the next period carries a pulse. A run input gates token propagation: dropping it parks the token at stage 0, clears the counter and forces the output low; raising it starts a fresh period from slot 0. A single-cycle strobe marks each ring revolution, giving a system clock enable at eight times the switching rate.

Top module: `hybrid_dpwm`

## Requirements
- R1: While rst_ni is low, and afterwards while run_i is low, pwm_o and sys_en_o are 0.
- R2: While running, consecutive rising edges of pwm_o are exactly 2^(CNT_W+TAP_W) clock cycles apart (256 by default).
- R3: pwm_o stays high for exactly d clock cycles per period, where d is the duty word captured at that period start; bits [7:5] are compared with the coarse counter and bits [4:0] select the ring stage.
- R4: A duty word below 8 gives a pulse of 8 cycles and one above 249 gives a pulse of 249 cycles.
- R5: The duty word is captured only on the cycle a period begins; a change of duty_i during a period does not alter the pulse of that period.
- R6: sys_en_o pulses for one cycle once per ring revolution, i.e. 2^CNT_W times per period (8 by default), with the ring holding exactly one token.
- R7: When run_i is low at a clock edge, pwm_o is 0 after that edge, including mid-pulse and on the edge where a period would start; sys_en_o stays 0 while stopped.
- R8: After run_i rises, pwm_o stays 0 after the first edge and goes high after the second edge, starting a period from slot 0 with the counter cleared.
- R9: en_i is captured at period start: if 0, that period has no pulse; changing en_i during a pulse does not shorten it.
- R10: With CNT_W=2 and TAP_W=2 (limits 1..14), a duty word of 11 gives a pulse of 11 cycles in a 16-cycle period with 4 revolution strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; one ring stage per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pulse enable, captured at period start |
| run_i | input | 1 | 1 lets the token circulate, 0 stops and parks it |
| duty_i | input | CNT_W+TAP_W | Duty word, slots of high time per period |
| pwm_o | output | 1 | Pulse-width modulated output |
| sys_en_o | output | 1 | One-cycle strobe per ring revolution |

## Verification
Two pairs of functions can land in one cycle: the stop command against the set of a new period, and a duty or enable change against the capture at period start. The bench drops run_i exactly on the edge where slot 0 would be processed and expects the output never to rise, and it changes duty_i and en_i on the cycle right after the capture edge, expecting the pulse then in flight to keep the previously captured width. Every duty value from 0 to 255 is swept, each judged against the arithmetically clamped width and the 256-cycle period.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_STOP = 2'd3
  } pwm_act_e;
endpackage

// File: rtl/hdpwm_ring.sv
module hdpwm_ring #(
  parameter int TAP_W = 5,
  localparam int RING_N = 1 << TAP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              park_i,
  input  logic              adv_i,
  output logic [RING_N-1:0] ring_o
);
  logic [RING_N-1:0] stage_q;

  for (genvar i = 0; i < RING_N; i++) begin : g_stage
    localparam int PREV = (i + RING_N - 1) % RING_N;
    localparam logic HOME = (i == 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[i] <= HOME;
      else if (park_i)  stage_q[i] <= HOME;
      else if (adv_i)   stage_q[i] <= stage_q[PREV];
    end
  end

  assign ring_o = stage_q;
endmodule

// File: rtl/hdpwm_coarse.sv
module hdpwm_coarse #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hdpwm_duty_latch.sv
module hdpwm_duty_latch #(
  parameter int W        = 8,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 249
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] duty_o
);
  localparam logic [W-1:0] LO = W'(DUTY_MIN);
  localparam logic [W-1:0] HI = W'(DUTY_MAX);

  logic [W-1:0] sat;
  logic [W-1:0] duty_q;

  always_comb begin
    if (duty_i < LO)      sat = LO;
    else if (duty_i > HI) sat = HI;
    else                  sat = duty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= LO;
    else if (load_i) duty_q <= sat;
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/hdpwm_sr_out.sv
module hdpwm_sr_out
  import hdpwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pwm_act_e act_i,
  output logic     pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else begin
      unique case (act_i)
        ACT_SET:            pwm_q <= 1'b1;
        ACT_CLR, ACT_STOP:  pwm_q <= 1'b0;
        default:            pwm_q <= pwm_q;
      endcase
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
  import hdpwm_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int TAP_W    = 5,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 249
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   run_i,
  input  logic [CNT_W+TAP_W-1:0] duty_i,
  output logic                   pwm_o,
  output logic                   sys_en_o
);
  localparam int DUTY_W = CNT_W + TAP_W;
  localparam int RING_N = 1 << TAP_W;

  logic              running_q;
  logic [RING_N-1:0] ring_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              adv;
  logic              slot0;
  logic              hit;
  pwm_act_e          act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) running_q <= 1'b0;
    else         running_q <= run_i;
  end

  // first run cycle only arms; token moves from the next one
  assign adv = run_i & running_q;

  hdpwm_ring #(.TAP_W(TAP_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .park_i (~run_i),
    .adv_i  (adv),
    .ring_o (ring_q)
  );

  hdpwm_coarse #(.CNT_W(CNT_W)) u_coarse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~run_i),
    .step_i  (adv & ring_q[RING_N-1]),
    .cnt_o   (cnt_q)
  );

  assign slot0 = running_q & ring_q[0] & (cnt_q == '0);
  assign hit   = running_q & ring_q[duty_q[TAP_W-1:0]]
               & (cnt_q == duty_q[DUTY_W-1:TAP_W]);

  hdpwm_duty_latch #(
    .W(DUTY_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (run_i & slot0),
    .duty_i (duty_i),
    .duty_o (duty_q)
  );

  always_comb begin
    if (!run_i)     act = ACT_STOP;
    else if (slot0) act = en_i ? ACT_SET : ACT_CLR;
    else if (hit)   act = ACT_CLR;
    else            act = ACT_HOLD;
  end

  hdpwm_sr_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .pwm_o  (pwm_o)
  );

  assign sys_en_o = running_q & ring_q[RING_N-1];
endmodule

// File: rtl/hybrid_dpwm_chk.sv
module hybrid_dpwm_chk #(
  parameter int CNT_W    = 3,
  parameter int TAP_W    = 5,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 249
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     run_i,
  input logic                     pwm_o,
  input logic                     running_q,
  input logic [(1<<TAP_W)-1:0]    ring_q,
  input logic [CNT_W-1:0]         cnt_q,
  input logic [CNT_W+TAP_W-1:0]   duty_q
);
  localparam int RING_N = 1 << TAP_W;

  p_stop_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_o);

  p_token_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) == 1);

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && running_q && ring_q[RING_N-1]) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_duty_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(duty_q) >= DUTY_MIN) && (int'(duty_q) <= DUTY_MAX));

  p_duty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && running_q && ring_q[0] && cnt_q == '0) |=> $stable(duty_q));

  p_rise_at_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(running_q && ring_q[0] && cnt_q == '0));
endmodule

bind hybrid_dpwm hybrid_dpwm_chk #(
  .CNT_W(CNT_W), .TAP_W(TAP_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .pwm_o     (pwm_o),
  .running_q (running_q),
  .ring_q    (ring_q),
  .cnt_q     (cnt_q),
  .duty_q    (duty_q)
);

// File: tb/hybrid_dpwm_test.sv
`timescale 1ns/1ps
module hybrid_dpwm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, run = 1'b0;
  logic [7:0] duty = 8'd100;
  logic pwm, sys_en;
  logic en_s = 1'b1, run_s = 1'b0;
  logic [3:0] duty_s = 4'd11;
  logic pwm_s, sys_en_s;
  logic sel = 1'b0;
  logic pwm_m, sys_m;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hybrid_dpwm uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .run_i(run),
    .duty_i(duty), .pwm_o(pwm), .sys_en_o(sys_en));

  hybrid_dpwm #(.CNT_W(2), .TAP_W(2), .DUTY_MIN(1), .DUTY_MAX(14)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_s), .run_i(run_s),
    .duty_i(duty_s), .pwm_o(pwm_s), .sys_en_o(sys_en_s));

  assign pwm_m = sel ? pwm_s : pwm;
  assign sys_m = sel ? sys_en_s : sys_en;

  function automatic int sat8(int v);
    if (v < 8) return 8;
    if (v > 249) return 249;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic l;
    l = pwm_m;
    @(negedge clk);
    while (!(pwm_m && !l)) begin
      l = pwm_m;
      @(negedge clk);
    end
  endtask

  // called at the sample where a rise was seen; returns at the next rise
  task automatic measure(output int h, output int t, output int s);
    logic l;
    bit fin;
    h = 1; t = 1; s = sys_m ? 1 : 0; l = 1'b1; fin = 0;
    while (!fin) begin
      @(negedge clk);
      if (pwm_m && !l) fin = 1;
      else begin
        t++;
        if (pwm_m) h++;
        if (sys_m) s++;
        l = pwm_m;
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int h, t, s, prev, cnt;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm), 0);
    chk("R1 sys_en in reset", int'(sys_en), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pwm stopped after reset", int'(pwm), 0);
    chk("R1 sys_en stopped after reset", int'(sys_en), 0);

    // start: first edge arms, second edge opens slot 0
    run = 1'b1;
    @(negedge clk);
    chk("R8 pwm after first edge", int'(pwm), 0);
    @(negedge clk);
    chk("R8 pwm after second edge", int'(pwm), 1);

    // full sweep; duty_i changed on the cycle after each capture
    prev = 100;
    for (int k = 0; k < 256; k++) begin
      duty = 8'(k);
      measure(h, t, s);
      if (k == 0)                  chk("R5 width kept after mid-period change", h, sat8(prev));
      else if (prev < 8 || prev > 249) chk("R4 clamped width", h, sat8(prev));
      else                         chk("R3 width", h, prev);
      chk("R2 period", t, 256);
      chk("R6 strobes per period", s, 8);
      prev = k;
    end

    // enable dropped right after capture: current pulse intact, next absent
    en = 1'b0;
    h = 0;
    while (pwm) begin h++; @(negedge clk); end
    chk("R9 pulse kept after en drop", h, 249);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm) cnt++;
    end
    chk("R9 no pulse with en low", cnt, 0);
    en = 1'b1;
    duty = 8'd60;
    wait_rise();
    measure(h, t, s);
    chk("R9 pulse resumes", h, 60);

    // stop on the edge that would open slot 0
    repeat (255) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R7 no set when stopped at period start", int'(pwm), 0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm || sys_en) cnt++;
    end
    chk("R7 outputs quiet while stopped", cnt, 0);

    duty = 8'd20;
    run = 1'b1;
    @(negedge clk);
    chk("R8 restart first edge", int'(pwm), 0);
    @(negedge clk);
    chk("R8 restart second edge", int'(pwm), 1);
    measure(h, t, s);
    chk("R8 restart width", h, 20);
    chk("R8 restart period", t, 256);

    // stop mid-pulse
    repeat (5) @(negedge clk);
    chk("R7 high before mid-pulse stop", int'(pwm), 1);
    run = 1'b0;
    @(negedge clk);
    chk("R7 low after mid-pulse stop", int'(pwm), 0);

    // reduced configuration
    sel = 1'b1;
    run_s = 1'b1;
    wait_rise();
    for (int p = 0; p < 3; p++) begin
      measure(h, t, s);
      chk("R10 small width", h, 11);
      chk("R10 small period", t, 16);
      chk("R10 small strobes", s, 4);
    end

    finish_run();
  end
endmodule